// File: doc/BRIEF.md
# Paired-Channel DMA Interrupt Aggregator

This block collects interrupt causes and run control for a DMA engine whose channels come in pairs. The channel index fixes each channel's direction: even channels move memory to device (transmit) and odd channels move device to memory (receive). The data path raises a descriptor-completed event and an error event for each channel. The block latches each event into a cause word. Every interrupt output has its own copy of that word and its own mask. Software clears cause bits by writing ones. For every output the block builds a transmit summary and a receive summary, one bit per channel pair. A global status word joins the summaries to form the interrupt line.

A run-control word per direction starts and stops channels. Bit p of the start field addresses channel 2p on the transmit side and channel 2p+1 on the receive side. Each channel has a two-state run machine, `RUN_IDLE` and `RUN_ACTIVE`. The transition START (`RUN_IDLE` to `RUN_ACTIVE`) needs a start request without a stop request. The transition STOP (`RUN_ACTIVE` to `RUN_IDLE`) needs a stop request. Any other request leaves the state unchanged. Each accepted request also produces a one-cycle strobe towards the channel.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset every cause, mask, global status bit and run flag is 0, and `irq`, `ch_start` and `ch_stop` are low.
- R2: The run-control word at address 0x000 acts on even channels and the one at 0x001 acts on odd channels. Bit p of the start field (bits 31:0) or of the stop field (bits 63:32) targets channel 2p or 2p+1 respectively.
- R3: A start request sets the channel's run flag, and a stop request clears it, one cycle after the write. When start and stop hit the same channel in one write, stop wins and only the stop strobe fires. Without a write the run flags hold.
- R4: Reading a run-control address returns the run flag of channel 2p (at 0x000) or 2p+1 (at 0x001) in bit p.
- R5: A `done_evt` or `err_evt` pulse sets cause bit 0 or bit 6, respectively, in the channel's cause word of every output. The cause word of channel c for output o reads at 0x100 + 8c + o.
- R6: Writing a 1 to cause bit 0 or 6 clears that bit in the addressed output's copy only. Zero bits change nothing. An event in the same cycle as the clear leaves the bit set.
- R7: The mask of channel c for output o is at 0x100 + 8c + 4 + o. It holds bits 0 and 6, with the same meaning as the cause word, and reads back what was written.
- R8: Bit p of the transmit summary of output o (0x010 + o) is 1 exactly when channel 2p has a cause bit set whose mask bit is also set. The receive summary (0x014 + o) does the same for channel 2p+1.
- R9: Bit g of `glob_evt` sets bit g of the global status of every output (read at 0x018 + o). A write of all ones to that address clears it, and any other value has no effect. A set in the same cycle as the clear wins.
- R10: `irq[o]` is the OR of output o's summaries and global status. An event shows on `irq` one cycle after it is applied.
- R11: `ch_start` and `ch_stop` are single-cycle pulses, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | DW | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | DW | Combinational read data |
| done_evt | input | NCHAN | Descriptor-completed event per channel |
| err_evt | input | NCHAN | Error event per channel |
| glob_evt | input | GLOB_W | Global miscellaneous status events |
| ch_run | output | NCHAN | Channel running flags |
| ch_start | output | NCHAN | Start strobe per channel |
| ch_stop | output | NCHAN | Stop strobe per channel |
| irq | output | NOUT | Interrupt outputs |

## Verification
Two collisions can occur in a single cycle. A hardware event can arrive while software writes a clear to the same cause bit or global status. A run-control write can carry both the start and the stop bit for the same channel. The bench forces both collisions in directed steps and also lets them arise from random traffic. The set-wins and stop-wins outcomes are judged against a bench model of the requirements, through `irq`, the run flags, the strobes and register reads.

// File: rtl/dia_pkg.sv
package dia_pkg;
    localparam int CAUSE_DONE  = 0;
    localparam int CAUSE_ERR   = 6;
    localparam int ADR_TX_RUN  = 'h000;
    localparam int ADR_RX_RUN  = 'h001;
    localparam int ADR_TX_SUM  = 'h010;
    localparam int ADR_RX_SUM  = 'h014;
    localparam int ADR_GLOB    = 'h018;
    localparam int ADR_CHAN    = 'h100;
    localparam int CHAN_STRIDE = 8;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;
endpackage

// File: rtl/dia_runctl.sv
module dia_runctl
    import dia_pkg::*;
#(
    parameter int NCHAN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCHAN-1:0] start_req,
    input  logic [NCHAN-1:0] stop_req,
    output logic [NCHAN-1:0] run,
    output logic [NCHAN-1:0] start_stb,
    output logic [NCHAN-1:0] stop_stb
);
    for (genvar ch = 0; ch < NCHAN; ch++) begin : g_ch
        run_state_e st_q, st_d;
        logic       go_q, halt_q;

        // state register
        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= RUN_IDLE;
            else        st_q <= st_d;
        end

        // next state: stop dominates start
        always_comb begin
            st_d = st_q;
            unique case (st_q)
                RUN_IDLE:   if (start_req[ch] && !stop_req[ch]) st_d = RUN_ACTIVE;
                RUN_ACTIVE: if (stop_req[ch])                   st_d = RUN_IDLE;
            endcase
        end

        // registered strobes, aligned with the state change
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                go_q   <= 1'b0;
                halt_q <= 1'b0;
            end else begin
                go_q   <= start_req[ch] && !stop_req[ch];
                halt_q <= stop_req[ch];
            end
        end

        assign run[ch]       = (st_q == RUN_ACTIVE);
        assign start_stb[ch] = go_q;
        assign stop_stb[ch]  = halt_q;
    end
endmodule

// File: rtl/dia_cause_bank.sv
module dia_cause_bank #(
    parameter int NCHAN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCHAN-1:0] done_evt,
    input  logic [NCHAN-1:0] err_evt,
    input  logic [NCHAN-1:0] clr_done,
    input  logic [NCHAN-1:0] clr_err,
    input  logic [NCHAN-1:0] mask_we,
    input  logic             mask_done_wd,
    input  logic             mask_err_wd,
    output logic [NCHAN-1:0] cause_done,
    output logic [NCHAN-1:0] cause_err,
    output logic [NCHAN-1:0] mask_done,
    output logic [NCHAN-1:0] mask_err,
    output logic [NCHAN-1:0] pend
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_done <= '0;
            cause_err  <= '0;
            mask_done  <= '0;
            mask_err   <= '0;
        end else begin
            // a fresh event overrides a simultaneous clear
            cause_done <= done_evt | (cause_done & ~clr_done);
            cause_err  <= err_evt  | (cause_err  & ~clr_err);
            mask_done  <= (mask_done & ~mask_we) | ({NCHAN{mask_done_wd}} & mask_we);
            mask_err   <= (mask_err  & ~mask_we) | ({NCHAN{mask_err_wd}}  & mask_we);
        end
    end

    assign pend = (cause_done & mask_done) | (cause_err & mask_err);
endmodule

// File: rtl/dia_glob_stat.sv
module dia_glob_stat #(
    parameter int GLOB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GLOB_W-1:0] set_evt,
    input  logic              clr_all,
    output logic [GLOB_W-1:0] stat
);
    always_ff @(posedge clk) begin
        if (!rst_n)       stat <= '0;
        else if (clr_all) stat <= set_evt;
        else              stat <= stat | set_evt;
    end
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import dia_pkg::*;
#(
    parameter int NCHAN  = 8,
    parameter int NOUT   = 4,
    parameter int GLOB_W = 8,
    parameter int ADDR_W = 10,
    parameter int DW     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [NCHAN-1:0]  done_evt,
    input  logic [NCHAN-1:0]  err_evt,
    input  logic [GLOB_W-1:0] glob_evt,
    output logic [NCHAN-1:0]  ch_run,
    output logic [NCHAN-1:0]  ch_start,
    output logic [NCHAN-1:0]  ch_stop,
    output logic [NOUT-1:0]   irq
);
    localparam int NPAIR  = NCHAN / 2;
    localparam int HALF   = DW / 2;
    localparam int SLOT_W = ADDR_W - 3;
    localparam logic [ADDR_W-1:0] AD_TXRUN = ADDR_W'(ADR_TX_RUN);
    localparam logic [ADDR_W-1:0] AD_RXRUN = ADDR_W'(ADR_RX_RUN);
    localparam logic [ADDR_W-1:0] AD_TXSUM = ADDR_W'(ADR_TX_SUM);
    localparam logic [ADDR_W-1:0] AD_RXSUM = ADDR_W'(ADR_RX_SUM);
    localparam logic [ADDR_W-1:0] AD_GLOB  = ADDR_W'(ADR_GLOB);
    localparam logic [ADDR_W-1:0] AD_CHAN  = ADDR_W'(ADR_CHAN);
    localparam logic [ADDR_W-1:0] AD_SPAN  = ADDR_W'(NCHAN * CHAN_STRIDE);

    logic [ADDR_W-1:0]            wofs, rofs;
    logic                         w_in_chan, r_in_chan;
    logic [NCHAN-1:0]             w_ch_sel;
    logic [NCHAN-1:0]             start_req, stop_req;
    logic                         tx_w, rx_w;
    logic [NOUT-1:0][NCHAN-1:0]   clr_done, clr_err, mask_we;
    logic [NOUT-1:0][NCHAN-1:0]   cd, ce, md, me, pend_all;
    logic [NOUT-1:0]              glob_clr;
    logic [NOUT-1:0][GLOB_W-1:0]  glob_q;
    logic [NOUT-1:0][NPAIR-1:0]   tx_sum, rx_sum;

    // ---------------- write decode ----------------
    always_comb begin
        wofs      = wr_addr - AD_CHAN;
        w_in_chan = (wr_addr >= AD_CHAN) && (wofs < AD_SPAN);
        for (int c = 0; c < NCHAN; c++)
            w_ch_sel[c] = w_in_chan && (wofs[ADDR_W-1:3] == SLOT_W'(c));
        for (int o = 0; o < NOUT; o++) begin
            clr_done[o] = w_ch_sel & {NCHAN{wr_en && !wofs[2] && (wofs[1:0] == 2'(o))
                                            && wr_data[CAUSE_DONE]}};
            clr_err[o]  = w_ch_sel & {NCHAN{wr_en && !wofs[2] && (wofs[1:0] == 2'(o))
                                            && wr_data[CAUSE_ERR]}};
            mask_we[o]  = w_ch_sel & {NCHAN{wr_en && wofs[2] && (wofs[1:0] == 2'(o))}};
            glob_clr[o] = wr_en && (wr_addr == AD_GLOB + ADDR_W'(o)) && (&wr_data);
        end
        tx_w = wr_en && (wr_addr == AD_TXRUN);
        rx_w = wr_en && (wr_addr == AD_RXRUN);
        for (int p = 0; p < NPAIR; p++) begin
            start_req[2*p]   = tx_w && wr_data[p];
            stop_req[2*p]    = tx_w && wr_data[HALF+p];
            start_req[2*p+1] = rx_w && wr_data[p];
            stop_req[2*p+1]  = rx_w && wr_data[HALF+p];
        end
    end

    // ---------------- run control ----------------
    dia_runctl #(.NCHAN(NCHAN)) u_runctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .run       (ch_run),
        .start_stb (ch_start),
        .stop_stb  (ch_stop)
    );

    // ---------------- per-output cause and global banks ----------------
    for (genvar o = 0; o < NOUT; o++) begin : g_out
        dia_cause_bank #(.NCHAN(NCHAN)) u_bank (
            .clk          (clk),
            .rst_n        (rst_n),
            .done_evt     (done_evt),
            .err_evt      (err_evt),
            .clr_done     (clr_done[o]),
            .clr_err      (clr_err[o]),
            .mask_we      (mask_we[o]),
            .mask_done_wd (wr_data[CAUSE_DONE]),
            .mask_err_wd  (wr_data[CAUSE_ERR]),
            .cause_done   (cd[o]),
            .cause_err    (ce[o]),
            .mask_done    (md[o]),
            .mask_err     (me[o]),
            .pend         (pend_all[o])
        );

        dia_glob_stat #(.GLOB_W(GLOB_W)) u_glob (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (glob_evt),
            .clr_all (glob_clr[o]),
            .stat    (glob_q[o])
        );
    end

    // ---------------- summaries and interrupt lines ----------------
    always_comb begin
        for (int o = 0; o < NOUT; o++) begin
            for (int p = 0; p < NPAIR; p++) begin
                tx_sum[o][p] = pend_all[o][2*p];
                rx_sum[o][p] = pend_all[o][2*p+1];
            end
            irq[o] = (|tx_sum[o]) | (|rx_sum[o]) | (|glob_q[o]);
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        rofs      = rd_addr - AD_CHAN;
        r_in_chan = (rd_addr >= AD_CHAN) && (rofs < AD_SPAN);
        rd_data   = '0;
        if (rd_addr == AD_TXRUN)
            for (int p = 0; p < NPAIR; p++) rd_data[p] = ch_run[2*p];
        if (rd_addr == AD_RXRUN)
            for (int p = 0; p < NPAIR; p++) rd_data[p] = ch_run[2*p+1];
        for (int o = 0; o < NOUT; o++) begin
            if (rd_addr == AD_TXSUM + ADDR_W'(o)) rd_data[NPAIR-1:0]  = tx_sum[o];
            if (rd_addr == AD_RXSUM + ADDR_W'(o)) rd_data[NPAIR-1:0]  = rx_sum[o];
            if (rd_addr == AD_GLOB  + ADDR_W'(o)) rd_data[GLOB_W-1:0] = glob_q[o];
        end
        if (r_in_chan)
            for (int c = 0; c < NCHAN; c++)
                for (int o = 0; o < NOUT; o++)
                    if ((rofs[ADDR_W-1:3] == SLOT_W'(c)) && (rofs[1:0] == 2'(o))) begin
                        rd_data[CAUSE_DONE] = rofs[2] ? md[o][c] : cd[o][c];
                        rd_data[CAUSE_ERR]  = rofs[2] ? me[o][c] : ce[o][c];
                    end
    end
endmodule

// File: rtl/dia_checker.sv
module dia_checker
    import dia_pkg::*;
#(
    parameter int NCHAN  = 8,
    parameter int NOUT   = 4,
    parameter int GLOB_W = 8,
    parameter int ADDR_W = 10,
    parameter int DW     = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic [GLOB_W-1:0] glob_evt,
    input logic [NCHAN-1:0]  ch_run,
    input logic [NCHAN-1:0]  ch_start,
    input logic [NCHAN-1:0]  ch_stop,
    input logic [NOUT-1:0]   irq
);
    localparam int NPAIR = NCHAN / 2;
    localparam int HALF  = DW / 2;

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(ch_start & ch_stop)));

    assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ch_run));

    assert_no_stray_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (ch_start == '0) && (ch_stop == '0));

    assert_glob_to_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|glob_evt) |=> (&irq));

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assert_stop_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(ADR_TX_RUN) && wr_data[HALF+p])
            |=> (!ch_run[2*p] && ch_stop[2*p]));

        assert_rx_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(ADR_RX_RUN) && wr_data[p] && !wr_data[HALF+p])
            |=> (ch_run[2*p+1] && ch_start[2*p+1]));
    end
endmodule

bind dma_irq_aggregator dia_checker #(
    .NCHAN(NCHAN), .NOUT(NOUT), .GLOB_W(GLOB_W), .ADDR_W(ADDR_W), .DW(DW)
) u_dia_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .glob_evt (glob_evt),
    .ch_run   (ch_run),
    .ch_start (ch_start),
    .ch_stop  (ch_stop),
    .irq      (irq)
);

// File: tb/tb_dma_irq_aggregator.sv
module tb_dma_irq_aggregator;
    localparam int NCHAN = 8, NOUT = 4, GLOB_W = 8, ADDR_W = 10, DW = 64;
    localparam int NPAIR = NCHAN / 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DW-1:0]     wr_data, rd_data;
    logic [NCHAN-1:0]  done_evt, err_evt, ch_run, ch_start, ch_stop;
    logic [GLOB_W-1:0] glob_evt;
    logic [NOUT-1:0]   irq;

    always #10 clk = ~clk;  // 50 MHz

    dma_irq_aggregator #(.NCHAN(NCHAN), .NOUT(NOUT), .GLOB_W(GLOB_W),
                         .ADDR_W(ADDR_W), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .done_evt(done_evt), .err_evt(err_evt),
        .glob_evt(glob_evt), .ch_run(ch_run), .ch_start(ch_start), .ch_stop(ch_stop),
        .irq(irq));

    // reference state, computed from the requirements
    logic [NOUT-1:0][NCHAN-1:0]  mcd, mce, mmd, mme;
    logic [NOUT-1:0][GLOB_W-1:0] mg;
    logic [NCHAN-1:0]            mrun, mst, msp;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic mpend(input int o, input int c);
        return (mcd[o][c] & mmd[o][c]) | (mce[o][c] & mme[o][c]);
    endfunction

    function automatic logic [NOUT-1:0] exp_irq();
        logic [NOUT-1:0] r;
        for (int o = 0; o < NOUT; o++) begin
            r[o] = |mg[o];
            for (int c = 0; c < NCHAN; c++) r[o] |= mpend(o, c);
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_rd(input logic [ADDR_W-1:0] a);
        logic [63:0] r = '0;
        if (a == 10'h000) for (int p = 0; p < NPAIR; p++) r[p] = mrun[2*p];
        if (a == 10'h001) for (int p = 0; p < NPAIR; p++) r[p] = mrun[2*p+1];
        for (int o = 0; o < NOUT; o++) begin
            if (a == 10'(16 + o)) for (int p = 0; p < NPAIR; p++) r[p] = mpend(o, 2*p);
            if (a == 10'(20 + o)) for (int p = 0; p < NPAIR; p++) r[p] = mpend(o, 2*p+1);
            if (a == 10'(24 + o)) r[GLOB_W-1:0] = mg[o];
            for (int c = 0; c < NCHAN; c++) begin
                if (a == 10'(256 + 8*c + o)) begin r[0] = mcd[o][c]; r[6] = mce[o][c]; end
                if (a == 10'(256 + 8*c + 4 + o)) begin r[0] = mmd[o][c]; r[6] = mme[o][c]; end
            end
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [ADDR_W-1:0] a);
        if (a < 10'h010) return "R4 run readback";
        if (a < 10'h018) return "R8 summary";
        if (a < 10'h100) return "R9 global status";
        if (a[2])        return "R7 mask";
        return "R6 cause";
    endfunction

    // one clocked step: apply stimulus, advance model, compare outputs
    task automatic step(input logic we, input logic [ADDR_W-1:0] a, input logic [63:0] d,
                        input logic [NCHAN-1:0] de, input logic [NCHAN-1:0] ee,
                        input logic [GLOB_W-1:0] ge);
        logic [NCHAN-1:0] st, sp;
        wr_en = we; wr_addr = a; wr_data = d; done_evt = de; err_evt = ee; glob_evt = ge;
        for (int p = 0; p < NPAIR; p++) begin
            st[2*p]   = we && a == 10'h000 && d[p];
            sp[2*p]   = we && a == 10'h000 && d[32+p];
            st[2*p+1] = we && a == 10'h001 && d[p];
            sp[2*p+1] = we && a == 10'h001 && d[32+p];
        end
        @(posedge clk);
        #1;
        for (int c = 0; c < NCHAN; c++) begin
            if (sp[c]) mrun[c] = 1'b0; else if (st[c]) mrun[c] = 1'b1;
            mst[c] = st[c] & ~sp[c];
            msp[c] = sp[c];
        end
        for (int o = 0; o < NOUT; o++) begin
            for (int c = 0; c < NCHAN; c++) begin
                if (we && a == 10'(256 + 8*c + o)) begin
                    if (d[0]) mcd[o][c] = 1'b0;
                    if (d[6]) mce[o][c] = 1'b0;
                end
                if (we && a == 10'(256 + 8*c + 4 + o)) begin
                    mmd[o][c] = d[0]; mme[o][c] = d[6];
                end
                if (de[c]) mcd[o][c] = 1'b1;
                if (ee[c]) mce[o][c] = 1'b1;
            end
            if (we && a == 10'(24 + o) && (&d)) mg[o] = '0;
            mg[o] |= ge;
        end
        wr_en = 0; done_evt = '0; err_evt = '0; glob_evt = '0;
        check("R10 irq", 64'(irq), 64'(exp_irq()));
        check("R3 run flags", 64'(ch_run), 64'(mrun));
        check("R11 start strobe", 64'(ch_start), 64'(mst));
        check("R3 stop strobe", 64'(ch_stop), 64'(msp));
    endtask

    task automatic rd_check(input logic [ADDR_W-1:0] a);
        rd_addr = a;
        #1;
        check(tag_of(a), rd_data, exp_rd(a));
    endtask

    function automatic logic [ADDR_W-1:0] rand_addr();
        int k = $urandom % 6;
        int c = $urandom % NCHAN;
        int o = $urandom % NOUT;
        case (k)
            0: return 10'($urandom % 2);
            1: return 10'(16 + ($urandom % 12));
            2, 3: return 10'(256 + 8*c + o);
            default: return 10'(256 + 8*c + 4 + o);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        mcd = '0; mce = '0; mmd = '0; mme = '0; mg = '0; mrun = '0; mst = '0; msp = '0;
        rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        done_evt = '0; err_evt = '0; glob_evt = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        check("R1 irq", 64'(irq), 64'h0);
        check("R1 run", 64'(ch_run), 64'h0);
        check("R1 strobes", 64'(ch_start | ch_stop), 64'h0);
        rd_check(10'h100); rd_check(10'h104); rd_check(10'h018); rd_check(10'h010);

        // R2/R3: start tx pair 1 (channel 2) and rx pair 0 (channel 1)
        step(1, 10'h000, 64'h2, '0, '0, '0);
        check("R2 tx pair1 -> ch2", 64'(ch_run), 64'h04);
        step(1, 10'h001, 64'h1, '0, '0, '0);
        check("R2 rx pair0 -> ch1", 64'(ch_run), 64'h06);
        rd_check(10'h000); rd_check(10'h001);
        // R3: start and stop on channel 2 in one write -> stop wins
        step(1, 10'h000, {32'h2, 32'h2}, '0, '0, '0);
        check("R3 stop wins run", 64'(ch_run[2]), 64'h0);
        check("R3 stop wins no start strobe", 64'(ch_start[2]), 64'h0);
        step(0, '0, '0, '0, '0, '0);
        check("R11 strobe single cycle", 64'(ch_stop), 64'h0);

        // R5/R7/R8/R10: mask done on ch3 out2, then event
        step(1, 10'(256 + 24 + 4 + 2), 64'h1, '0, '0, '0);
        step(0, '0, '0, 8'h08, '0, '0);
        check("R10 irq out2 from ch3", 64'(irq), 64'h4);
        rd_check(10'(20 + 2));
        check("R8 rx sum bit1", rd_data, 64'h2);
        rd_check(10'(256 + 24 + 0));
        check("R5 cause copy out0", rd_data, 64'h1);

        // R6: clear collides with new event -> stays set
        step(1, 10'(256 + 24 + 2), 64'h41, 8'h08, '0, '0);
        rd_check(10'(256 + 24 + 2));
        check("R6 set beats clear", rd_data, 64'h1);
        step(1, 10'(256 + 24 + 2), 64'h40, '0, '0, '0);
        rd_check(10'(256 + 24 + 2));
        check("R6 zero bit ignored", rd_data, 64'h1);
        step(1, 10'(256 + 24 + 2), 64'h1, '0, '0, '0);
        check("R6 clear drops irq", 64'(irq), 64'h0);
        rd_check(10'(256 + 24 + 1));
        check("R6 other copy kept", rd_data, 64'h1);

        // R9: global status
        step(0, '0, '0, '0, '0, 8'h81);
        check("R9 glob sets all irqs", 64'(irq), 64'hF);
        step(1, 10'(24 + 1), 64'hFFFF_FFFF_FFFF_FFFE, '0, '0, '0);
        rd_check(10'(24 + 1));
        check("R9 partial write ignored", rd_data, 64'h81);
        step(1, 10'(24 + 1), '1, '0, '0, 8'h10);
        rd_check(10'(24 + 1));
        check("R9 set beats clear-all", rd_data, 64'h10);
        step(1, 10'(24 + 1), '1, '0, '0, '0);
        rd_check(10'(24 + 1));
        check("R9 clear-all", rd_data, 64'h0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [ADDR_W-1:0] a;
            logic [63:0] d;
            a = rand_addr();
            d = {$urandom, $urandom};
            if (a >= 10'h018 && a < 10'h01C && ($urandom % 2 == 0)) d = '1;
            if (a >= 10'h100 && a[2] == 1'b0 && ($urandom % 2 == 0)) d = 64'h41;
            step(($urandom % 3) != 0, a,
                 d,
                 ($urandom % 4 == 0) ? NCHAN'($urandom) : '0,
                 ($urandom % 5 == 0) ? NCHAN'($urandom) : '0,
                 ($urandom % 16 == 0) ? GLOB_W'($urandom) : '0);
            rd_check(rand_addr());
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule